// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block moves bytes over a two-wire I2C bus as the only master. Software drives it through five 8-bit registers: a clock divider, an own-address holder, a control register, a status register and a data register. Each register travels in bits 31:24 of a 32-bit word. No command strobe exists. START and STOP follow the rising and falling edges of one control bit. A repeated START comes from a self-clearing control bit. Each byte transfer starts as a side effect of a data-register access: a write in transmit mode, or a read in receive mode.

Both bus lines are open-drain. The block drives only output-enable signals, where 1 pulls the line low, and it samples the resolved line levels. One bit period is four quarter steps, and each step lasts divider+1 system clocks. A separate line monitor follows START and STOP conditions on the wires, whichever master caused them, and reports a bus-busy bit.

Top module: `i2c_byte_master`

## Requirements
- R1: Register select codes are divider=0, own address=1, control=2, status=3, data=4. Every register reads and writes in reg_wdata/reg_rdata bits 31:24, and bits 23:0 of reg_rdata read as zero.
- R2: A START goes out on the lines when control bit 5 (master) changes from 0 to 1 while control bit 7 (enable) is 1 and the bus is idle. Clearing bit 5 afterwards sends a STOP. Status bit 5 (bus busy) reads 1 between the two and 0 after the STOP.
- R3: While control bit 4 (transmit) is 1, a data write sends the byte MSB first followed by a ninth clock. Afterwards status bit 1 (byte done) is 1, and status bit 0 holds the sampled acknowledge, where 1 means NACK.
- R4: While bit 4 is 0, the first data read after entering receive mode is a dummy that only starts a reception. Every later read returns the previous received byte and starts the next one. After the STOP, a read returns the final byte without starting another.
- R5: When control bit 3 is 1 as a reception starts, the master answers that byte with NACK. Otherwise it answers with ACK.
- R6: Writing control bit 2 as 1 while the block owns the bus sends a repeated START without a STOP. The bit reads back as 0.
- R7: Writing status with bit 1 at 0 clears byte-done. Writing it as 1 leaves the flag unchanged.
- R8: With enable at 0, no START and no transfer occurs, and both lines stay released.
- R9: Status bit 5 follows START and STOP conditions driven by another master. While it is 1, no START is issued.
- R10: While a command or byte is in progress, status bit 7 reads 1, and data-register accesses are ignored.
- R11: SDA changes while SCL is released only to form START, repeated START or STOP.
- R12: The SCL high time is 2*(divider+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wdata | input | 32 | Write data, register in bits 31:24 |
| reg_rdata | output | 32 | Read data, register in bits 31:24 |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A bus-accurate slave model in the bench answers a fixed address. The bench runs seeded random write and register-read transactions, with random byte counts, payloads and dividers. Some transactions use a matching address and some a non-matching one. The matching cases show that bits are serialized MSB first and that the dummy-read offset is right. The non-matching cases show that a NACK is sampled into the status register and not a fixed zero. Single-byte reads set NACK on the dummy read, and multi-byte reads set it only on the last byte, which separates the two acknowledge paths. Directed cases cover a foreign master holding the bus, enable at 0, accesses during a transfer, and a write of 1 to byte-done.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
    localparam int REG_W   = 8;
    localparam int REG_LSB = 24;
    localparam int BUS_W   = REG_LSB + REG_W;

    localparam logic [2:0] SEL_DIV  = 3'd0;
    localparam logic [2:0] SEL_OWN  = 3'd1;
    localparam logic [2:0] SEL_CTRL = 3'd2;
    localparam logic [2:0] SEL_STAT = 3'd3;
    localparam logic [2:0] SEL_DATA = 3'd4;

    localparam int CB_EN   = 7;
    localparam int CB_MAST = 5;
    localparam int CB_TX   = 4;
    localparam int CB_NACK = 3;
    localparam int CB_RSTA = 2;

    localparam int SB_XFER = 7;
    localparam int SB_BUSY = 5;
    localparam int SB_DONE = 1;
    localparam int SB_RXNK = 0;

    typedef enum logic [2:0] {
        OP_NONE, OP_START, OP_RESTART, OP_STOP, OP_WRITE, OP_READ
    } op_e;
endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_bm_busmon.sv
module i2c_bm_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic bus_busy
);
    logic [SYNC_STAGES-1:0] scl_s, sda_s;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_s <= '1;
                    sda_s <= '1;
                end else begin
                    scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
                    sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_s <= '1;
                    sda_s <= '1;
                end else begin
                    scl_s <= scl_i;
                    sda_s <= sda_i;
                end
            end
        end
    endgenerate

    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic busy;
    } mon_t;

    mon_t mon_d, mon_q;
    logic scl_now, sda_now;

    assign scl_now = scl_s[SYNC_STAGES-1];
    assign sda_now = sda_s[SYNC_STAGES-1];

    always_comb begin
        mon_d       = mon_q;
        mon_d.scl_p = scl_now;
        mon_d.sda_p = sda_now;
        if (scl_now && mon_q.scl_p && mon_q.sda_p && !sda_now) mon_d.busy = 1'b1;
        if (scl_now && mon_q.scl_p && !mon_q.sda_p && sda_now) mon_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0};
        else        mon_q <= mon_d;
    end

    assign bus_busy = mon_q.busy;
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
    import i2c_bm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  op_e               op,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              nack_out,
    input  logic              tick,
    input  logic              sda_i,
    output logic              busy,
    output logic              cond_active,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rbyte,
    output logic              rack,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    typedef struct packed {
        op_e               op;
        logic [1:0]        ph;
        logic [CNT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic              nack;
        logic              rack;
        logic              scl_oe;
        logic              sda_oe;
        logic              done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.op == OP_NONE) begin
            if (go) begin
                d.op   = op;
                d.ph   = '0;
                d.bitn = '0;
                d.nack = nack_out;
                d.sh   = (op == OP_WRITE) ? wbyte : '0;
            end
        end else if (tick) begin
            d.ph = q.ph + 2'd1;
            unique case (q.op)
                OP_START: begin
                    if (q.ph == 2'd0) begin d.sda_oe = 1'b0; d.scl_oe = 1'b0; end
                    if (q.ph == 2'd1) d.sda_oe = 1'b1;
                    if (q.ph == 2'd3) begin d.scl_oe = 1'b1; d.op = OP_NONE; end
                end
                OP_RESTART: begin
                    if (q.ph == 2'd0) d.sda_oe = 1'b0;
                    if (q.ph == 2'd1) d.scl_oe = 1'b0;
                    if (q.ph == 2'd2) d.sda_oe = 1'b1;
                    if (q.ph == 2'd3) begin d.scl_oe = 1'b1; d.op = OP_NONE; end
                end
                OP_STOP: begin
                    if (q.ph == 2'd0) d.sda_oe = 1'b1;
                    if (q.ph == 2'd1) d.scl_oe = 1'b0;
                    if (q.ph == 2'd2) d.sda_oe = 1'b0;
                    if (q.ph == 2'd3) d.op = OP_NONE;
                end
                default: begin
                    case (q.ph)
                        2'd0: begin
                            if (q.bitn == ACK_SLOT) d.sda_oe = (q.op == OP_READ) && !q.nack;
                            else                    d.sda_oe = (q.op == OP_WRITE) && !q.sh[BYTE_W-1];
                        end
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: begin
                            if (q.bitn == ACK_SLOT) d.rack = sda_i;
                            else                    d.sh   = {q.sh[BYTE_W-2:0], sda_i};
                        end
                        default: begin
                            d.scl_oe = 1'b1;
                            if (q.bitn == ACK_SLOT) begin
                                d.op   = OP_NONE;
                                d.done = 1'b1;
                            end else begin
                                d.bitn = q.bitn + 1'b1;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{op: OP_NONE, default: '0};
        else        q <= d;
    end

    assign busy        = (q.op != OP_NONE);
    assign cond_active = (q.op == OP_START) || (q.op == OP_RESTART) || (q.op == OP_STOP);
    assign byte_done   = q.done;
    assign rbyte       = q.sh;
    assign rack        = q.rack;
    assign scl_oe      = q.scl_oe;
    assign sda_oe      = q.sda_oe;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe
);
    typedef struct packed {
        logic [REG_W-1:0] div;
        logic [REG_W-1:0] own;
        logic [REG_W-1:0] ctrl;
        logic             irq;
        logic             rxnack;
        logic             owner;
        logic             rd_xfer;
        logic [REG_W-1:0] rdat;
    } regs_t;

    regs_t st_d, st_q;

    logic [REG_W-1:0] wb, rsel;
    logic             eng_go, eng_nack, eng_busy, eng_cond, byte_done, eng_rack, tick, bus_busy;
    op_e              eng_op;
    logic [REG_W-1:0] eng_rbyte;
    logic             unused_low;

    assign wb         = reg_wdata[BUS_W-1:REG_LSB];
    assign unused_low = ^reg_wdata[REG_LSB-1:0];

    i2c_bm_tick #(.DIV_W(REG_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(st_q.div), .tick(tick)
    );

    i2c_bm_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .bus_busy(bus_busy)
    );

    i2c_bm_engine #(.BYTE_W(REG_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .op(eng_op), .wbyte(wb),
        .nack_out(eng_nack), .tick(tick), .sda_i(sda_i), .busy(eng_busy),
        .cond_active(eng_cond), .byte_done(byte_done), .rbyte(eng_rbyte),
        .rack(eng_rack), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_comb begin
        st_d     = st_q;
        eng_go   = 1'b0;
        eng_op   = OP_NONE;
        eng_nack = st_q.ctrl[CB_NACK];
        if (reg_wr) begin
            case (reg_sel)
                SEL_DIV: st_d.div = wb;
                SEL_OWN: st_d.own = wb;
                SEL_CTRL: begin
                    st_d.ctrl          = wb;
                    st_d.ctrl[CB_RSTA] = 1'b0;
                    if (wb[CB_EN] && !eng_busy) begin
                        if (wb[CB_MAST] && !st_q.ctrl[CB_MAST] && !st_q.owner && !bus_busy) begin
                            eng_go     = 1'b1;
                            eng_op     = OP_START;
                            st_d.owner = 1'b1;
                        end else if (!wb[CB_MAST] && st_q.ctrl[CB_MAST] && st_q.owner) begin
                            eng_go     = 1'b1;
                            eng_op     = OP_STOP;
                            st_d.owner = 1'b0;
                        end else if (wb[CB_RSTA] && st_q.owner) begin
                            eng_go = 1'b1;
                            eng_op = OP_RESTART;
                        end
                    end
                end
                SEL_STAT: if (!wb[SB_DONE]) st_d.irq = 1'b0;
                SEL_DATA: begin
                    if (st_q.ctrl[CB_EN] && st_q.ctrl[CB_TX] && st_q.owner && !eng_busy) begin
                        eng_go       = 1'b1;
                        eng_op       = OP_WRITE;
                        st_d.rd_xfer = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (reg_rd && reg_sel == SEL_DATA && st_q.ctrl[CB_EN] && !st_q.ctrl[CB_TX]
            && st_q.owner && !eng_busy) begin
            eng_go       = 1'b1;
            eng_op       = OP_READ;
            st_d.rd_xfer = 1'b1;
        end
        if (byte_done) begin
            st_d.irq = 1'b1;
            if (st_q.rd_xfer) st_d.rdat   = eng_rbyte;
            else              st_d.rxnack = eng_rack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_DIV:  rsel = st_q.div;
            SEL_OWN:  rsel = st_q.own;
            SEL_CTRL: rsel = st_q.ctrl;
            SEL_STAT: rsel = {eng_busy, 1'b0, bus_busy, 3'b000, st_q.irq, st_q.rxnack};
            SEL_DATA: rsel = st_q.rdat;
            default:  rsel = '0;
        endcase
    end

    assign reg_rdata = {rsel, {REG_LSB{1'b0}}};
endmodule

// File: rtl/i2c_bm_checks.sv
module i2c_bm_checks
    import i2c_bm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             eng_go,
    input op_e              eng_op,
    input logic             eng_busy,
    input logic             eng_cond,
    input logic             bus_busy,
    input logic [REG_W-1:0] ctrl_q,
    input logic             irq_q,
    input logic             byte_done,
    input logic             reg_wr,
    input logic [2:0]       reg_sel,
    input logic [BUS_W-1:0] reg_wdata,
    input logic             scl_oe,
    input logic             sda_oe
);
    p_sda_only_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> eng_cond);

    p_cmd_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> !eng_busy);

    p_cmd_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> ctrl_q[CB_EN]);

    p_start_on_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && eng_op == OP_START) |-> !bus_busy);

    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_STAT && !reg_wdata[REG_LSB+SB_DONE] && !byte_done) |=> !irq_q);
endmodule

bind i2c_byte_master i2c_bm_checks u_checks (
    .clk(clk), .rst_n(rst_n), .eng_go(eng_go), .eng_op(eng_op), .eng_busy(eng_busy),
    .eng_cond(eng_cond), .bus_busy(bus_busy), .ctrl_q(st_q.ctrl), .irq_q(st_q.irq),
    .byte_done(byte_done), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
    localparam logic [2:0] S_DIV = 3'd0, S_OWN = 3'd1, S_CTRL = 3'd2, S_STAT = 3'd3, S_DATA = 3'd4;
    localparam logic [7:0] EN = 8'h80, MS = 8'h20, TX = 8'h10, NK = 8'h08, RS = 8'h04;
    localparam logic [6:0] SLV = 7'h3A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] reg_sel = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic scl_oe, sda_oe;
    logic ext_sda_low = 1'b0, drv = 1'b0;
    wire scl_line = !scl_oe;
    wire sda_line = !sda_oe && !drv && !ext_sda_low;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] cur_div = 8'd1;

    i2c_byte_master uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #10 clk = ~clk;

    // slave model and bus observers
    logic [7:0] rmem [64];
    logic [7:0] wlog [64];
    logic       mlog [64];
    int wcnt = 0, mcnt = 0, ridx = 0, starts = 0, stops = 0, bitn = 0;
    int hi_cnt = 0, last_hi = 0;
    logic p_scl = 1'b1, p_sda = 1'b1, act = 1'b0, first = 1'b0, rd = 1'b0, m_nack = 1'b0;
    logic [7:0] sh = '0, txb = '0;

    always @(negedge clk) begin
        if (scl_line) hi_cnt++;
        else begin
            if (hi_cnt > 0) last_hi = hi_cnt;
            hi_cnt = 0;
        end
        if (scl_line && p_scl && p_sda && !sda_line) begin
            starts++; bitn = 0; first = 1; act = 1; rd = 0; drv = 0;
        end else if (scl_line && p_scl && !p_sda && sda_line) begin
            stops++; act = 0; drv = 0;
        end else if (act && scl_line && !p_scl) begin
            if (bitn < 8) begin sh = {sh[6:0], sda_line}; bitn++; end
            else begin m_nack = sda_line; bitn = 9; end
        end else if (act && !scl_line && p_scl) begin
            if (bitn == 8) begin
                if (first) begin
                    drv = (sh[7:1] == SLV);
                    rd  = sh[0];
                    if (sh[7:1] != SLV) act = 0;
                end else if (rd) drv = 0;
                else begin wlog[wcnt % 64] = sh; wcnt++; drv = 1; end
            end else if (bitn == 9) begin
                bitn = 0;
                if (rd && !first) begin mlog[mcnt % 64] = m_nack; mcnt++; end
                if (rd && (first || !m_nack)) begin
                    txb = rmem[ridx % 64]; ridx++; drv = !txb[7];
                end else drv = 0;
                first = 0;
            end else if (rd && !first && bitn < 8) drv = !txb[7-bitn];
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = {v, 24'h0}; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            reg_read(S_STAT, v);
            if (!v[31]) break;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_nack);
        logic [31:0] v;
        reg_write(S_DATA, b);
        wait_idle();
        reg_read(S_STAT, v);
        chk(v[25] == 1'b1, "R3 byte-done set", {31'd0, v[25]}, 32'd1);
        chk(v[24] == exp_nack, "R3 received ack", {31'd0, v[24]}, {31'd0, exp_nack});
        reg_write(S_STAT, 8'h00);
    endtask

    task automatic do_start();
        logic [31:0] v;
        reg_write(S_CTRL, EN | TX);
        reg_write(S_CTRL, EN | TX | MS);
        wait_idle();
        reg_read(S_STAT, v);
        chk(v[29] == 1'b1, "R2 busy after START", {31'd0, v[29]}, 32'd1);
    endtask

    task automatic do_stop();
        logic [31:0] v;
        reg_write(S_CTRL, EN | TX);
        wait_idle();
        repeat (10) @(negedge clk);
        reg_read(S_STAT, v);
        chk(v[29] == 1'b0, "R2 idle after STOP", {31'd0, v[29]}, 32'd0);
        chk(!scl_oe && !sda_oe, "R2 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    endtask

    task automatic tx_write(input bit match, input int n);
        logic [7:0] expb [8];
        int wbase = wcnt, sbase = starts, pbase = stops;
        do_start();
        send_byte({match ? SLV : (SLV ^ 7'h55), 1'b0}, !match);
        chk(last_hi == 2 * (cur_div + 1), "R12 SCL high time", last_hi, 2 * (cur_div + 1));
        if (match) begin
            for (int k = 0; k < n; k++) begin
                expb[k] = 8'($urandom);
                send_byte(expb[k], 1'b0);
            end
        end
        do_stop();
        chk(starts == sbase + 1 && stops == pbase + 1, "R11 no stray conditions",
            starts - sbase, 1);
        if (match) begin
            chk(wcnt == wbase + n, "R3 byte count", wcnt - wbase, n);
            for (int k = 0; k < n; k++)
                chk(wlog[(wbase + k) % 64] == expb[k], "R3 MSB-first data",
                    wlog[(wbase + k) % 64], expb[k]);
        end else chk(wcnt == wbase, "R3 nothing logged on NACK", wcnt - wbase, 0);
    endtask

    task automatic tx_read(input int n);
        logic [31:0] v;
        int rbase, mbase, sbase, pbase;
        do_start();
        send_byte({SLV, 1'b0}, 1'b0);
        send_byte(8'($urandom), 1'b0);
        sbase = starts; pbase = stops;
        reg_write(S_CTRL, EN | TX | MS | RS);
        wait_idle();
        chk(starts == sbase + 1 && stops == pbase, "R6 repeated START", starts - sbase, 1);
        reg_read(S_CTRL, v);
        chk(v[26] == 1'b0, "R6 bit self-clears", {31'd0, v[26]}, 32'd0);
        rbase = ridx;
        send_byte({SLV, 1'b1}, 1'b0);
        mbase = mcnt;
        reg_write(S_CTRL, EN | MS | ((n == 1) ? NK : 8'h00));
        reg_read(S_DATA, v);
        wait_idle();
        reg_write(S_STAT, 8'h00);
        for (int k = 1; k < n; k++) begin
            if (k == n - 1) reg_write(S_CTRL, EN | MS | NK);
            reg_read(S_DATA, v);
            chk(v[31:24] == rmem[(rbase + k - 1) % 64], "R4 previous byte",
                v[31:24], rmem[(rbase + k - 1) % 64]);
            wait_idle();
            reg_write(S_STAT, 8'h00);
        end
        reg_write(S_CTRL, EN);
        wait_idle();
        reg_read(S_DATA, v);
        chk(v[31:24] == rmem[(rbase + n - 1) % 64], "R4 final byte",
            v[31:24], rmem[(rbase + n - 1) % 64]);
        chk(mcnt == mbase + n, "R5 acknowledge count", mcnt - mbase, n);
        for (int k = 0; k < n; k++)
            chk(mlog[(mbase + k) % 64] == (k == n - 1), "R5 master ACK/NACK",
                {31'd0, mlog[(mbase + k) % 64]}, (k == n - 1) ? 32'd1 : 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed_init;
        seed_init = $urandom(32'h5EED);
        for (int i = 0; i < 64; i++) rmem[i] = 8'($urandom);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        reg_read(S_STAT, v);
        chk(v == 32'h0, "R1 status after reset", v, 32'h0);
        reg_read(S_CTRL, v);
        chk(v == 32'h0, "R1 control after reset", v, 32'h0);
        reg_write(S_DIV, 8'h5A);
        reg_read(S_DIV, v);
        chk(v == 32'h5A00_0000, "R1 divider readback", v, 32'h5A00_0000);
        reg_write(S_OWN, 8'hC3);
        reg_read(S_OWN, v);
        chk(v == 32'hC300_0000, "R1 own-address readback", v, 32'hC300_0000);

        reg_write(S_DIV, 8'd1);
        reg_write(S_CTRL, MS | TX);
        reg_write(S_DATA, 8'hA5);
        repeat (60) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R8 disabled lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
        reg_read(S_STAT, v);
        chk(v[31:24] == 8'h00, "R8 disabled status", v[31:24], 32'h0);
        reg_write(S_CTRL, 8'h00);

        ext_sda_low = 1'b1;
        repeat (6) @(negedge clk);
        reg_read(S_STAT, v);
        chk(v[29] == 1'b1, "R9 foreign START seen", {31'd0, v[29]}, 32'd1);
        reg_write(S_CTRL, EN | TX | MS);
        repeat (40) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R9 no START on busy bus", {30'd0, scl_oe, sda_oe}, 32'd0);
        reg_write(S_CTRL, EN | TX);
        ext_sda_low = 1'b0;
        repeat (6) @(negedge clk);
        reg_read(S_STAT, v);
        chk(v[29] == 1'b0, "R9 foreign STOP seen", {31'd0, v[29]}, 32'd0);

        begin
            int wbase;
            wbase = wcnt;
            do_start();
            send_byte({SLV, 1'b0}, 1'b0);
            reg_write(S_DATA, 8'h6C);
            reg_write(S_DATA, 8'h93);
            reg_read(S_STAT, v);
            chk(v[31] == 1'b1, "R10 in-progress bit", {31'd0, v[31]}, 32'd1);
            wait_idle();
            reg_write(S_STAT, 8'h02);
            reg_read(S_STAT, v);
            chk(v[25] == 1'b1, "R7 writing 1 keeps flag", {31'd0, v[25]}, 32'd1);
            reg_write(S_STAT, 8'h00);
            reg_read(S_STAT, v);
            chk(v[25] == 1'b0, "R7 writing 0 clears flag", {31'd0, v[25]}, 32'd0);
            do_stop();
            chk(wcnt == wbase + 1 && wlog[wbase % 64] == 8'h6C, "R10 second write ignored",
                {wlog[wbase % 64], 24'(wcnt - wbase)}, {8'h6C, 24'd1});
        end

        for (int t = 0; t < 12; t++) begin
            int sel, n;
            cur_div = 8'(1 + $urandom % 5);
            reg_write(S_DIV, cur_div);
            sel = $urandom % 4;
            n = 1 + $urandom % 4;
            if (t < 2) sel = t + 1;
            if (sel == 0) tx_write(1'b0, n);
            else if (sel == 1) tx_write(1'b1, n);
            else tx_read((t == 2) ? 1 : n);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule